// File: doc/BRIEF.md
# Fractional UART Baud Tick Generator

This block derives the timing strobes for a UART receiver or transmitter from a fast system clock. A 16-bit divisor is read as a fixed-point number: a 12-bit whole part N and a 4-bit fraction. Each oversample period lasts either N or N+1 system clocks. A small fraction accumulator decides which one, and it spreads the longer periods as evenly as possible across the bit. The average oversample period therefore equals the programmed fractional divisor, while each complete bit still lasts an exact whole number of clocks.

A mode input selects 16x or 8x oversampling. The block emits three one-cycle strobes: one per oversample period, one at each bit boundary, and one on each of the three oversample ticks that form the majority-vote window in the middle of the bit. A frame-start input lets the receiver realign the whole pattern to a detected start bit. A new divisor or mode is taken in only at a bit boundary or while the block is disabled, so no bit is ever cut short.

Top module: `frac_baud_tick_gen`

## Requirements
- R1: In 16x mode the whole part N is divisor bits [15:4] and the fraction F is bits [3:0]. Each bit lasts exactly the raw 16-bit divisor value in clocks (16·N + F).
- R2: In 8x mode divisor bit 3 is ignored and F is bits [2:0]. Each bit lasts exactly 8·N + F clocks.
- R3: Every oversample interval is either N or N+1 clocks long. Within one bit, exactly F intervals have the N+1 length.
- R4: With OS = 16 (or 8 in 8x mode), the k-th oversample interval of a bit (k = 1..OS) is N+1 clocks exactly when floor(k·F/OS) > floor((k−1)·F/OS), and N clocks otherwise.
- R5: `bit_tick` pulses together with the last oversample tick of each bit (the 16th, or the 8th in 8x mode). After `enable` rises, the first enabled cycle counts as clock 1 of the first bit.
- R6: `sample_tick` pulses together with oversample ticks 8, 9 and 10 of each bit in 16x mode, and with ticks 4, 5 and 6 in 8x mode. That gives exactly three pulses per bit.
- R7: While the whole part N is zero, no strobe is produced.
- R8: A divisor or mode change while enabled first takes effect in the bit that follows the next bit boundary. While disabled, the value present in the last disabled cycle is used.
- R9: In a cycle with `frame_start` high no strobe is produced. The cycle after it is clock 1 of a fresh bit, with the dither pattern restarted.
- R10: During reset and while `enable` is low, all three strobes stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Runs the generator; low holds it cleared and open to a new divisor |
| os8_mode | input | 1 | 1 selects 8x oversampling, 0 selects 16x |
| divisor | input | 16 | Fixed-point divisor, whole part in [15:4], fraction in [3:0] |
| frame_start | input | 1 | One-cycle pulse that restarts bit timing at a start bit |
| os_tick | output | 1 | One-cycle oversample strobe |
| bit_tick | output | 1 | One-cycle strobe at the end of each bit |
| sample_tick | output | 1 | One-cycle strobe on the three mid-bit oversample ticks |

## Verification
The bench builds the block with its default widths: a 12-bit whole part and a 4-bit fraction. This puts the minimum whole part of one, where an oversample tick can fall on every clock, within reach. It also covers fractions of zero and of the largest value in both oversampling modes, and an 8x divisor whose ignored bit 3 is set. Every oversample interval of several consecutive bits is compared with the closed-form dither rule. The bench also exercises a divisor and mode change in the middle of a bit, a frame restart on a cycle where a tick was due, and a zero whole part.

// File: rtl/frac_baud_pkg.sv
// Shared constants for the fractional baud tick generator.
// Assumes the divisor is a whole part followed by a fraction field.
package frac_baud_pkg;
    localparam int unsigned DEF_INT_W  = 12;
    localparam int unsigned DEF_FRAC_W = 4;
    localparam int unsigned MID_SPAN   = 3;
endpackage

// File: rtl/fbt_div_hold.sv
// Holds the divisor fields and the oversampling mode in use.
// Loads whenever load is high (disabled, or at a bit boundary). In 8x mode
// the top fraction bit is dropped here, so downstream logic sees F < 8.
module fbt_div_hold #(
    parameter int unsigned INT_W  = 12,
    parameter int unsigned FRAC_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [INT_W+FRAC_W-1:0] div_in,
    input  logic                    mode8_in,
    output logic [INT_W-1:0]        int_q,
    output logic [FRAC_W-1:0]       frac_q,
    output logic                    mode8_q
);
    // Capture the divisor fields and mode on a load request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_q   <= '0;
            frac_q  <= '0;
            mode8_q <= 1'b0;
        end else if (load) begin
            int_q   <= div_in[INT_W+FRAC_W-1:FRAC_W];
            mode8_q <= mode8_in;
            frac_q  <= mode8_in ? {1'b0, div_in[FRAC_W-2:0]} : div_in[FRAC_W-1:0];
        end
    end
endmodule

// File: rtl/fbt_dither.sv
// Fraction accumulator that chooses N or N+1 for each oversample period.
// extra is the carry that the coming step would produce. It is FRAC_W bits
// wide in 16x mode and one bit narrower in 8x mode.
module fbt_dither #(
    parameter int unsigned FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    input  logic              mode8,
    input  logic [FRAC_W-1:0] frac,
    output logic              extra
);
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]   sum;

    // Form the next accumulator sum and the carry out at the width for the mode.
    always_comb begin
        sum   = {1'b0, acc} + {1'b0, frac};
        extra = mode8 ? sum[FRAC_W-1] : sum[FRAC_W];
    end

    // Advance the accumulator by one step per oversample tick, modulo the mode width.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc <= '0;
        end else if (step) begin
            acc <= mode8 ? {1'b0, sum[FRAC_W-2:0]} : sum[FRAC_W-1:0];
        end
    end
endmodule

// File: rtl/fbt_phase.sv
// Clock counter and oversample index. Produces the three strobes.
// Assumes int_n >= 1 whenever run is high. The period in use is int_n + extra.
module fbt_phase #(
    parameter int unsigned INT_W  = 12,
    parameter int unsigned FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              run,
    input  logic              mode8,
    input  logic [INT_W-1:0]  int_n,
    input  logic              extra,
    output logic              os_tick,
    output logic              bit_tick,
    output logic              sample_tick
);
    localparam int unsigned CNT_W = INT_W + 1;
    localparam int unsigned OS16  = 1 << FRAC_W;
    localparam logic [FRAC_W-1:0] LAST16 = FRAC_W'(OS16 - 1);
    localparam logic [FRAC_W-1:0] LAST8  = FRAC_W'(OS16 / 2 - 1);
    localparam logic [FRAC_W-1:0] MID16  = FRAC_W'(OS16 / 2 - 1);
    localparam logic [FRAC_W-1:0] MID8   = FRAC_W'(OS16 / 4 - 1);
    localparam logic [FRAC_W-1:0] SPAN   = FRAC_W'(frac_baud_pkg::MID_SPAN - 1);

    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  len;
    logic [FRAC_W-1:0] idx;
    logic [FRAC_W-1:0] last_idx;
    logic [FRAC_W-1:0] mid_lo;

    // Decode the strobes from the counters and the period length in use.
    always_comb begin
        len         = {1'b0, int_n} + {{INT_W{1'b0}}, extra};
        last_idx    = mode8 ? LAST8 : LAST16;
        mid_lo      = mode8 ? MID8 : MID16;
        os_tick     = run && (cnt == len - CNT_W'(1));
        bit_tick    = os_tick && (idx == last_idx);
        sample_tick = os_tick && (idx >= mid_lo) && (idx <= mid_lo + SPAN);
    end

    // Count clocks within the current oversample period.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (os_tick) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Count oversample ticks within the current bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx <= '0;
        end else if (os_tick) begin
            idx <= (idx == last_idx) ? '0 : idx + FRAC_W'(1);
        end
    end
endmodule

// File: rtl/frac_baud_tick_gen.sv
// Top of the fractional baud tick generator. Latches the divisor, dithers
// the oversample period between N and N+1 clocks, and emits the strobes.
// Assumes frame_start is a one-cycle pulse from the start-bit detector.
module frac_baud_tick_gen #(
    parameter int unsigned INT_W  = frac_baud_pkg::DEF_INT_W,
    parameter int unsigned FRAC_W = frac_baud_pkg::DEF_FRAC_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic                    os8_mode,
    input  logic [INT_W+FRAC_W-1:0] divisor,
    input  logic                    frame_start,
    output logic                    os_tick,
    output logic                    bit_tick,
    output logic                    sample_tick
);
    logic [INT_W-1:0]  div_int;
    logic [FRAC_W-1:0] div_frac;
    logic              mode8_q;
    logic              run;
    logic              restart;
    logic              extra;

    // Run only with a valid whole part and outside a restart cycle.
    always_comb begin
        restart = !enable || frame_start;
        run     = enable && (div_int != '0) && !frame_start;
    end

    fbt_div_hold #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (!enable || bit_tick),
        .div_in  (divisor),
        .mode8_in(os8_mode),
        .int_q   (div_int),
        .frac_q  (div_frac),
        .mode8_q (mode8_q)
    );

    fbt_dither #(.FRAC_W(FRAC_W)) u_dither (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (restart || bit_tick),
        .step (os_tick),
        .mode8(mode8_q),
        .frac (div_frac),
        .extra(extra)
    );

    fbt_phase #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (restart),
        .run        (run),
        .mode8      (mode8_q),
        .int_n      (div_int),
        .extra      (extra),
        .os_tick    (os_tick),
        .bit_tick   (bit_tick),
        .sample_tick(sample_tick)
    );
endmodule

// File: rtl/fbt_checker.sv
// Property checker for the fractional baud tick generator, bound to the top.
// Measures the oversample spacing and the mid-bit sample count with counters.
module fbt_checker #(
    parameter int unsigned INT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             frame_start,
    input logic             run,
    input logic [INT_W-1:0] int_n,
    input logic             os_tick,
    input logic             bit_tick,
    input logic             sample_tick
);
    logic [INT_W:0] gap;
    logic           seen_os;
    logic [2:0]     smp;
    logic           seen_bit;

    // Track clocks since the last oversample tick and samples since the last bit end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            gap      <= '0;
            seen_os  <= 1'b0;
            smp      <= '0;
            seen_bit <= 1'b0;
        end else begin
            if (os_tick) begin
                gap     <= '0;
                seen_os <= 1'b1;
            end else if (gap != '1) begin
                gap <= gap + 1'b1;
            end
            if (bit_tick) begin
                smp      <= '0;
                seen_bit <= 1'b1;
            end else if (sample_tick && smp != 3'd7) begin
                smp <= smp + 3'd1;
            end
        end
    end

    a_r3_os_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (os_tick && seen_os) |-> ((gap + 1'b1 == {1'b0, int_n}) || (gap == {1'b0, int_n})));

    a_r5_bit_on_os: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);

    a_r6_sample_on_os: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick |-> (os_tick && !bit_tick));

    a_r6_three_samples: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && seen_bit) |-> (smp == 3'd3));

    a_r7_zero_int: assert property (@(posedge clk) disable iff (!rst_n)
        (int_n == '0) |-> !(os_tick || bit_tick || sample_tick));

    a_r9_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !(os_tick || bit_tick || sample_tick));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !(os_tick || bit_tick || sample_tick));
endmodule

bind frac_baud_tick_gen fbt_checker #(.INT_W(INT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .frame_start(frame_start),
    .run        (run),
    .int_n      (div_int),
    .os_tick    (os_tick),
    .bit_tick   (bit_tick),
    .sample_tick(sample_tick)
);

// File: tb/frac_baud_tick_gen_tb.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table of divisor/mode cases, then directed tests.
module frac_baud_tick_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        os8_mode = 1'b0;
    logic [15:0] divisor = '0;
    logic        frame_start = 1'b0;
    logic        os_tick, bit_tick, sample_tick;

    int n_chk = 0;
    int n_fail = 0;

    // {mode8, divisor}
    localparam logic [16:0] VEC [0:7] = '{
        17'h00010, 17'h00011, 17'h0001F, 17'h00235,
        17'h000A7, 17'h10018, 17'h1001F, 17'h10124
    };

    frac_baud_tick_gen u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .os8_mode(os8_mode),
        .divisor(divisor), .frame_start(frame_start),
        .os_tick(os_tick), .bit_tick(bit_tick), .sample_tick(sample_tick)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Disable, present a new setting, then enable; the next negedge is clock 1.
    task automatic start(input logic [15:0] d, input logic m8);
        @(posedge clk); #1;
        enable = 1'b0; divisor = d; os8_mode = m8;
        @(posedge clk); #1;
        enable = 1'b1;
    endtask

    // Sample until n bit ticks are seen (or limit clocks); return their clock numbers.
    task automatic find_bits(input int limit, output int b1, output int b2);
        int nb = 0;
        b1 = -1; b2 = -1;
        for (int c = 1; c <= limit; c++) begin
            @(negedge clk);
            if (bit_tick) begin
                if (nb == 0) b1 = c; else if (nb == 1) b2 = c;
                nb++;
            end
        end
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int quiet;
        int b1, b2;
        // R10: strobes low during reset and while disabled.
        quiet = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (os_tick || bit_tick || sample_tick) quiet++;
        end
        check(quiet == 0, "R10 reset", quiet, 0);
        @(posedge clk); #1; rst_n = 1'b1; divisor = 16'h0010;
        quiet = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (os_tick || bit_tick || sample_tick) quiet++;
        end
        check(quiet == 0, "R10 disabled", quiet, 0);

        // Vector walk: R1, R2, R3, R4, R5, R6.
        for (int v = 0; v < 8; v++) begin
            logic [15:0] d;
            logic m8;
            int n, f, os, bitlen, clk_no;
            d = VEC[v][15:0]; m8 = VEC[v][16];
            n = int'(d[15:4]);
            f = m8 ? int'(d[2:0]) : int'(d[3:0]);
            os = m8 ? 8 : 16;
            bitlen = m8 ? 8 * n + f : int'(d);
            start(d, m8);
            clk_no = 0;
            for (int b = 1; b <= 3; b++) begin
                int bit_seen = -1;
                int stray = 0;
                for (int k = 1; k <= os; k++) begin
                    int len;
                    bit exp_smp;
                    len = n + (k * f) / os - ((k - 1) * f) / os;
                    exp_smp = m8 ? (k >= 4 && k <= 6) : (k >= 8 && k <= 10);
                    for (int j = 1; j < len; j++) begin
                        @(negedge clk); clk_no++;
                        if (os_tick || bit_tick || sample_tick) stray++;
                    end
                    @(negedge clk); clk_no++;
                    if (bit_tick) bit_seen = clk_no;
                    // R3/R4: interval length by the dither rule; R5/R6: strobe alignment.
                    check(os_tick && (bit_tick == (k == os)) && (sample_tick == exp_smp),
                          "R4 os interval / R5 / R6 strobes",
                          {os_tick, bit_tick, sample_tick}, {1'b1, k == os, exp_smp});
                end
                check(stray == 0, "R3 no early tick", stray, 0);
                check(bit_seen == b * bitlen, m8 ? "R2 8x bit period" : "R1 16x bit period",
                      bit_seen, b * bitlen);
            end
        end

        // R7: zero whole part gives no strobes.
        start(16'h0007, 1'b0);
        quiet = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (os_tick || bit_tick || sample_tick) quiet++;
        end
        check(quiet == 0, "R7 zero integer", quiet, 0);

        // R8: change to 8x, divisor 0x0035 (3*8+5 = 29) during the first 32-clock bit.
        start(16'h0020, 1'b0);
        for (int i = 0; i < 5; i++) @(negedge clk);
        @(posedge clk); #1; divisor = 16'h0035; os8_mode = 1'b1;
        find_bits(70 - 5, b1, b2);
        check(b1 + 5 == 32, "R8 old bit kept", b1 + 5, 32);
        check(b2 + 5 == 61, "R8 new bit applied", b2 + 5, 61);

        // R8: changes while disabled use the last disabled value.
        @(posedge clk); #1; enable = 1'b0; divisor = 16'h0100; os8_mode = 1'b0;
        @(posedge clk); #1; divisor = 16'h0022;
        @(posedge clk); #1; enable = 1'b1;
        find_bits(40, b1, b2);
        check(b1 == 34, "R8 latch while disabled", b1, 34);

        // R9: frame_start on a cycle where a tick was due restarts the bit.
        start(16'h0020, 1'b0);
        for (int i = 0; i < 9; i++) @(negedge clk);
        @(posedge clk); #1; frame_start = 1'b1;
        @(negedge clk);
        check(!(os_tick || bit_tick || sample_tick), "R9 quiet on restart",
              {os_tick, bit_tick, sample_tick}, 0);
        @(posedge clk); #1; frame_start = 1'b0;
        find_bits(40, b1, b2);
        check(b1 == 32, "R9 fresh bit after restart", b1, 32);

        // R10: dropping enable stops strobes.
        @(posedge clk); #1; enable = 1'b0;
        quiet = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (os_tick || bit_tick || sample_tick) quiet++;
        end
        check(quiet == 0, "R10 disable stops", quiet, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule